// File: doc/BRIEF.md
# DMA Channel Descriptor Coherency Controller

This block keeps the control state of one DMA channel descriptor and settles the race between software rewriting that descriptor and the transfer engine retiring the channel at the end of its major loop. It holds the done flag, the major-link enable, the link-channel number, the scatter/gather enable and the request-disable flag. From these it decides whether a late scatter/gather or link request is honoured or dropped.

Software reaches the control word through a plain register write/read port. The engine reports when the channel begins execution and when it retires. The block answers a retire with a one-cycle reload strobe, which is a request to fetch the next descriptor, or with a one-cycle link request that carries the target channel number. A write to the control word that lands while done is set cannot arm either enable. The retire therefore reaches a definite outcome, and software can tell the outcome from one read of the word.

Hardware activation requests pass through a gate. A retire taken with request-disable set closes the gate. This stops the channel from running again with stale addresses after a dynamic request has failed. Every pin is a plain control or status strobe, so no interface carries back-pressure.

Top module: `dsc_coherency_ctrl`

## Requirements
- R1: The control word sits at address CTRL_ADDR with this layout: bit 0 done, bit 1 request-disable, bit 2 scatter/gather enable, bit 3 link enable, and bits [CH_W+3:4] link channel. A read of any other address returns 0, a write to any other address changes nothing, and every field resets to 0.
- R2: A control-word write with bit 0 = 1 while done is set stores link enable = 0 and scatter/gather enable = 0, whatever values were written. The other fields take the written values.
- R3: A control-word write with bit 0 = 0 clears done before the mask is applied, so both enables are stored as written.
- R4: The link-channel field reads back exactly as last written, whatever the link enable holds.
- R5: An engine start strobe clears done in the following cycle.
- R6: A retire while the scatter/gather enable is 1 raises sg_reload for exactly the next cycle, leaves done unchanged and raises no link request.
- R7: A retire while the scatter/gather enable is 0 sets done. If link enable is 1, link_req is high for exactly the next cycle, and link_ch_out then equals the stored link channel.
- R8: When a control-word write and a retire fall in the same cycle, the retire acts on the values held before the write. The write is then judged against the done flag that the retire has just produced. An engine start in the same cycle takes effect after the retire and before the write.
- R9: A retire taken while request-disable is 1 holds act_req low from the next cycle, whatever hw_req does. This lasts until a control-word write stores request-disable = 0.
- R10: While the gate is open, act_req follows hw_req in the same cycle.
- R11: Writing 1 to bit 0 never sets done. Only a retire sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | CH_W+4 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | CH_W+4 | Read data, combinational |
| eng_start | input | 1 | Engine begins channel execution |
| eng_retire | input | 1 | Engine retires the channel at major-loop end |
| hw_req | input | 1 | Hardware activation request |
| act_req | output | 1 | Gated activation request to the engine |
| sg_reload | output | 1 | One-cycle scatter/gather reload strobe |
| link_req | output | 1 | One-cycle channel link request |
| link_ch_out | output | CH_W | Channel number carried by link_req |

## Verification
The bench aims at cycles where a control-word write, a start and a retire coincide. A design that let the write win over the retire would either honour a scatter/gather request that arrived too late or drop one that was already armed. It also covers writes that clear done while setting the enables. A design that masked before clearing would silently lose those enables. It drives hardware requests across the blocked window to catch a gate that reopens early or never closes, and it checks that writing 1 to done leaves done clear.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DONE_B  = 0;
  localparam int DREQ_B  = 1;
  localparam int SG_B    = 2;
  localparam int LINK_B  = 3;
  localparam int LCH_LSB = 4;

  typedef struct packed {
    logic link_en;
    logic sg_en;
    logic dreq;
    logic done;
  } dcc_flags_t;
endpackage

// File: rtl/dcc_ctrl_word.sv
module dcc_ctrl_word
  import dcc_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_done,
  input  logic            clr_done,
  input  logic            wr_ctrl,
  input  logic            wr_done,
  input  logic            wr_dreq,
  input  logic            wr_sg,
  input  logic            wr_link,
  input  logic [CH_W-1:0] wr_lch,
  output dcc_flags_t      flags_q,
  output logic [CH_W-1:0] lch_q
);
  dcc_flags_t      flags_n;
  logic [CH_W-1:0] lch_n;
  logic            done_mid;
  logic            done_wr;

  // Order inside one cycle: retire sets, start clears, then the write.
  always_comb begin
    done_mid = (flags_q.done | set_done) & ~clr_done;
    done_wr  = done_mid & wr_done;
    flags_n  = flags_q;
    lch_n    = lch_q;
    flags_n.done = done_mid;
    if (wr_ctrl) begin
      flags_n.done = done_wr;
      flags_n.dreq = wr_dreq;
      lch_n        = wr_lch;
      if (done_wr) begin
        flags_n.link_en = 1'b0;
        flags_n.sg_en   = 1'b0;
      end else begin
        flags_n.link_en = wr_link;
        flags_n.sg_en   = wr_sg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      lch_q   <= '0;
    end else begin
      flags_q <= flags_n;
      lch_q   <= lch_n;
    end
  end

  a_r2_enables_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_done && flags_q.done && !clr_done) |=> (!flags_q.link_en && !flags_q.sg_en));

  a_r3_clear_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_done) |=>
      (!flags_q.done && flags_q.link_en == $past(wr_link) && flags_q.sg_en == $past(wr_sg)));

  a_r4_lch_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (lch_q == $past(wr_lch)));

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !flags_q.done);

  a_r11_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q.done && !set_done) |=> !flags_q.done);
endmodule

// File: rtl/dcc_retire.sv
module dcc_retire
  import dcc_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire,
  input  dcc_flags_t      flags_q,
  input  logic [CH_W-1:0] lch_q,
  output logic            set_done,
  output logic            sg_reload,
  output logic            link_req,
  output logic [CH_W-1:0] link_ch_out
);
  logic take_sg;
  logic take_link;

  // Enables are sampled from storage only here, at retire time.
  always_comb begin
    take_sg   = retire & flags_q.sg_en;
    set_done  = retire & ~flags_q.sg_en;
    take_link = set_done & flags_q.link_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_reload   <= 1'b0;
      link_req    <= 1'b0;
      link_ch_out <= '0;
    end else begin
      sg_reload <= take_sg;
      link_req  <= take_link;
      if (take_link) link_ch_out <= lch_q;
    end
  end

  a_r6_reload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && flags_q.sg_en) |=> (sg_reload && !link_req));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sg_reload && link_req));

  a_r7_link_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !flags_q.sg_en && flags_q.link_en) |=> (link_req && link_ch_out == $past(lch_q)));

  a_r7_no_link_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire || !flags_q.link_en) |=> !link_req);
endmodule

// File: rtl/dcc_act_gate.sv
module dcc_act_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic retire,
  input  logic dreq_q,
  input  logic wr_ctrl,
  input  logic wr_dreq,
  input  logic hw_req,
  output logic act_req
);
  logic blocked_q;
  logic blocked_n;

  always_comb begin
    blocked_n = blocked_q | (retire & dreq_q);
    if (wr_ctrl && !wr_dreq) blocked_n = 1'b0;
    act_req = hw_req & ~blocked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= blocked_n;
  end

  a_r9_blocked_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && dreq_q && !(wr_ctrl && !wr_dreq)) |=> !act_req);

  a_r9_stay_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_q && !(wr_ctrl && !wr_dreq)) |=> !act_req);
endmodule

// File: rtl/dsc_coherency_ctrl.sv
module dsc_coherency_ctrl
  import dcc_pkg::*;
#(
  parameter  int CH_W      = 5,
  parameter  int ADDR_W    = 3,
  parameter  int CTRL_ADDR = 7,
  localparam int WORD_W    = CH_W + LCH_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              eng_start,
  input  logic              eng_retire,
  input  logic              hw_req,
  output logic              act_req,
  output logic              sg_reload,
  output logic              link_req,
  output logic [CH_W-1:0]   link_ch_out
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic            wr_ctrl;
  logic            set_done;
  dcc_flags_t      flags_q;
  logic [CH_W-1:0] lch_q;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_A);

  dcc_ctrl_word #(.CH_W(CH_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (set_done),
    .clr_done (eng_start),
    .wr_ctrl  (wr_ctrl),
    .wr_done  (wr_data[DONE_B]),
    .wr_dreq  (wr_data[DREQ_B]),
    .wr_sg    (wr_data[SG_B]),
    .wr_link  (wr_data[LINK_B]),
    .wr_lch   (wr_data[LCH_LSB +: CH_W]),
    .flags_q  (flags_q),
    .lch_q    (lch_q)
  );

  dcc_retire #(.CH_W(CH_W)) u_retire (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire      (eng_retire),
    .flags_q     (flags_q),
    .lch_q       (lch_q),
    .set_done    (set_done),
    .sg_reload   (sg_reload),
    .link_req    (link_req),
    .link_ch_out (link_ch_out)
  );

  dcc_act_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .retire  (eng_retire),
    .dreq_q  (flags_q.dreq),
    .wr_ctrl (wr_ctrl),
    .wr_dreq (wr_data[DREQ_B]),
    .hw_req  (hw_req),
    .act_req (act_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A) begin
      rd_data[DONE_B] = flags_q.done;
      rd_data[DREQ_B] = flags_q.dreq;
      rd_data[SG_B]   = flags_q.sg_en;
      rd_data[LINK_B] = flags_q.link_en;
      for (int i = 0; i < CH_W; i++) rd_data[LCH_LSB+i] = lch_q[i];
    end
  end

  a_r8_write_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_retire && wr_ctrl && !flags_q.sg_en && !eng_start && wr_data[DONE_B])
      |=> (!flags_q.link_en && !flags_q.sg_en && flags_q.done));

  a_r1_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !eng_retire && !eng_start) |=> $stable(flags_q) && $stable(lch_q));
endmodule

// File: tb/dsc_coherency_ctrl_bench.sv
module dsc_coherency_ctrl_bench;
  localparam int CH_W = 5;
  localparam int AW   = 3;
  localparam int CA   = 7;
  localparam int WW   = CH_W + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, eng_start = 1'b0, eng_retire = 1'b0, hw_req = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = AW'(CA);
  logic [WW-1:0] wr_data = '0;
  logic [WW-1:0] rd_data;
  logic          act_req, sg_reload, link_req;
  logic [CH_W-1:0] link_ch_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_done, m_dreq, m_sg, m_link, m_blk, m_sgr, m_lr;
  int m_lch, m_lch_o;

  always #4 clk = ~clk;

  dsc_coherency_ctrl #(.CH_W(CH_W), .ADDR_W(AW), .CTRL_ADDR(CA)) u_dsc_coherency_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_start(eng_start), .eng_retire(eng_retire),
    .hw_req(hw_req), .act_req(act_req), .sg_reload(sg_reload), .link_req(link_req),
    .link_ch_out(link_ch_out)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (rd_addr == AW'(CA)) begin
      chk("R5 R7 R11 done bit", int'(rd_data[0]), int'(m_done));
      chk("R1 R9 request-disable bit", int'(rd_data[1]), int'(m_dreq));
      chk("R2 R3 R8 sg enable", int'(rd_data[2]), int'(m_sg));
      chk("R2 R3 R8 link enable", int'(rd_data[3]), int'(m_link));
      chk("R4 link channel field", int'(rd_data[WW-1:4]), m_lch);
    end else begin
      chk("R1 foreign address read", int'(rd_data), 0);
    end
    chk("R6 sg_reload", int'(sg_reload), int'(m_sgr));
    chk("R7 link_req", int'(link_req), int'(m_lr));
    if (m_lr) chk("R7 link_ch_out", int'(link_ch_out), m_lch_o);
    chk("R9 R10 act_req", int'(act_req), int'(hw_req && !m_blk));
  endtask

  task automatic model_step();
    bit d;
    bit pre_sg, pre_link, pre_dreq;
    d = m_done; pre_sg = m_sg; pre_link = m_link; pre_dreq = m_dreq;
    m_sgr = 0; m_lr = 0;
    if (eng_retire) begin
      if (pre_sg) m_sgr = 1;
      else begin
        d = 1;
        if (pre_link) begin m_lr = 1; m_lch_o = m_lch; end
      end
      if (pre_dreq) m_blk = 1;
    end
    if (eng_start) d = 0;
    if (wr_en && wr_addr == AW'(CA)) begin
      if (!wr_data[0]) d = 0;
      if (d) begin m_link = 0; m_sg = 0; end
      else begin m_link = wr_data[3]; m_sg = wr_data[2]; end
      m_dreq = wr_data[1];
      m_lch = int'(wr_data[WW-1:4]);
      if (!wr_data[1]) m_blk = 0;
    end
    m_done = d;
  endtask

  // one cycle: drive after falling edge, compare, then advance model at rising edge
  task automatic cyc(bit we, int wa, int wd, bit st, bit rt, bit hw, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = WW'(wd);
    eng_start = st; eng_retire = rt; hw_req = hw; rd_addr = AW'(ra);
    #1 compare_all();
    @(posedge clk);
    model_step();
  endtask

  function automatic int word(int lch, bit link, bit sg, bit dq, bit dn);
    return (lch << 4) | (int'(link) << 3) | (int'(sg) << 2) | (int'(dq) << 1) | int'(dn);
  endfunction

  initial begin
    #(8 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_done = 0; m_dreq = 0; m_sg = 0; m_link = 0; m_blk = 0; m_sgr = 0; m_lr = 0;
    m_lch = 0; m_lch_o = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();                                   // R1 reset state
    rst_n = 1'b1;
    // R4: link channel as free storage with link disabled
    cyc(1, CA, word(21, 0, 0, 0, 0), 0, 0, 1, CA);
    cyc(0, 0, 0, 0, 0, 1, CA);
    // R1: foreign address write ignored, foreign read is zero
    cyc(1, 3, 9'h1FF, 0, 0, 0, 3);
    cyc(0, 0, 0, 0, 0, 0, CA);
    // R7: arm link, retire -> done and link pulse
    cyc(1, CA, word(9, 1, 0, 0, 0), 0, 0, 0, CA);
    cyc(0, 0, 0, 0, 1, 0, CA);
    cyc(0, 0, 0, 0, 0, 0, CA);
    // R2: write enables while done -> masked; R11 done bit 1 does not set
    cyc(1, CA, word(9, 1, 1, 0, 1), 0, 0, 0, CA);
    cyc(0, 0, 0, 0, 0, 0, CA);
    // R3: clear done and arm sg in one word
    cyc(1, CA, word(4, 0, 1, 0, 0), 0, 0, 0, CA);
    cyc(0, 0, 0, 1, 0, 0, CA);                       // R5 start
    cyc(0, 0, 0, 0, 1, 0, CA);                       // R6 reload
    cyc(0, 0, 0, 0, 0, 0, CA);
    // R8: write arming sg in the retire cycle, sg off before
    cyc(1, CA, word(2, 1, 0, 0, 0), 0, 0, 0, CA);
    cyc(1, CA, word(2, 0, 1, 0, 1), 0, 1, 0, CA);
    cyc(0, 0, 0, 0, 0, 1, CA);
    // R9 R10: request-disable closes gate until cleared
    cyc(1, CA, word(1, 0, 0, 1, 0), 0, 0, 1, CA);
    cyc(0, 0, 0, 0, 1, 1, CA);
    cyc(0, 0, 0, 0, 0, 1, CA);
    cyc(0, 0, 0, 1, 0, 1, CA);
    cyc(1, CA, word(1, 0, 0, 0, 0), 0, 0, 1, CA);
    cyc(0, 0, 0, 0, 0, 1, CA);
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 3,
          (($urandom % 10) < 8) ? CA : int'($urandom % CA),
          int'($urandom),
          ($urandom % 10) == 0,
          ($urandom % 8) == 0,
          ($urandom % 2) == 1,
          (($urandom % 10) < 9) ? CA : int'($urandom % CA));
    end
    cyc(0, 0, 0, 0, 0, 0, CA);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule